// File: doc/BRIEF.md
# Pointer-Addressed Configuration Register Bank with Table Window

This block is the target-side register bank that sits behind a byte-level serial bus framing layer. The framing layer reports when a transaction opens and closes, hands over each received byte, and asks for one byte whenever the bus master reads. The bank holds thirteen byte-wide configuration registers and a table of 128 coarse/fine byte pairs. The table has no direct address. Software sets a table-address register and then goes through two window registers.

A write transaction is held in a small receive buffer until it closes. Its first byte sets the register pointer. Each later byte is stored at the pointer, and the pointer then moves forward, wrapping after the last register. Reads return the byte at the pointer and also advance it. Each write into a timer or PWM register group raises a one-cycle reconfigure strobe for that group. A write into the second window register commits the pair to the table and raises a commit strobe that carries the table address and both bytes, so an outside persistence unit can store them.

Top module: `winreg_bank`

## Requirements
- R1: After reset, registers 0..12 hold 4, 123, 8, 127, 4, 9, 123, 8, 127, 254, 0, 0, 0 (register i on cfg_flat bits [8i+7:8i]). Every table byte is 0, the pointer is 0, and rd_data and all strobes are 0.
- R2: The first byte of an accepted transaction loads the pointer. A value of 13 or more loads 0. A transaction that carries only this byte changes no register, so the next read returns the register it selected.
- R3: Each byte after the first is stored into the register at the pointer, and the pointer then increments, going from 12 back to 0.
- R4: A one-cycle rd_req pulse puts the byte selected by the pointer on rd_data in the following cycle, and advances the pointer with the same wrap as R3.
- R5: Let A be register 10. A read at index 11 returns table byte 2A and a read at index 12 returns table byte 2A+1, not the register contents. Register 10 stores only the low 7 bits of a written byte, with bit 7 read as 0.
- R6: A write at index 12 puts register 11 (its value at that moment) into table byte 2A and the written byte into table byte 2A+1. It also pulses commit_valid for one cycle, with commit_addr=A, commit_hi=that register 11 value and commit_lo=the written byte.
- R7: Each written byte gives exactly one one-cycle pulse: tmr0_reinit for indices 0..2, pwm0_update for 3..4, tmr1_reinit for 5..7, pwm1_update for 8..9, and no pulse for 10..12. At most one of these four is high in any cycle.
- R8: A transaction that closes with zero bytes, or with more than RX_DEPTH bytes (default 8), changes no register or pointer and gives no strobe. A transaction of exactly RX_DEPTH bytes is applied.
- R9: No register, strobe or commit reacts to received bytes before txn_stop. The bytes are then applied in order, one per clock, and all are done within n+2 cycles for an n-byte transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Transaction opens; clears the receive buffer |
| txn_stop | input | 1 | Transaction closes; triggers apply or discard |
| rx_valid | input | 1 | rx_byte holds a received byte this cycle |
| rx_byte | input | 8 | Received byte |
| rd_req | input | 1 | Master reads one byte |
| rd_data | output | 8 | Read byte, valid the cycle after rd_req |
| tmr0_reinit | output | 1 | Pulse: register 0..2 written |
| pwm0_update | output | 1 | Pulse: register 3..4 written |
| tmr1_reinit | output | 1 | Pulse: register 5..7 written |
| pwm1_update | output | 1 | Pulse: register 8..9 written |
| commit_valid | output | 1 | Pulse: table pair committed |
| commit_addr | output | 7 | Table pair index of the commit |
| commit_hi | output | 8 | Coarse byte committed |
| commit_lo | output | 8 | Fine byte committed |
| cfg_flat | output | 104 | All thirteen registers, register i at bits [8i+7:8i] |

## Verification
Directed transactions separate the pointer-only case from a real write, and separate an out-of-range pointer byte from a valid one. Multi-byte writes that start at index 12 show whether the pointer wraps to 0 or runs past the end. Window reads taken before and after register 10 changes show whether indices 11 and 12 are served from the table or from the registers. Length-boundary transactions (zero, RX_DEPTH and RX_DEPTH+1 bytes) separate the discard rule from the accept rule. Seeded random transactions with random pointers and lengths then exercise the group strobes and the commit path, and full register sweeps compare the bank against a bench model.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

    localparam int NREG       = 13;
    localparam int IDX_W      = 4;
    localparam int TAB_PAIRS  = 128;
    localparam int TAB_AW     = $clog2(TAB_PAIRS);
    localparam int TAB_BYTES  = 2 * TAB_PAIRS;

    localparam logic [IDX_W-1:0] IDX_TADDR = 4'd10;
    localparam logic [IDX_W-1:0] IDX_THI   = 4'd11;
    localparam logic [IDX_W-1:0] IDX_TLO   = 4'd12;

    typedef logic [7:0]       byte_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [2:0] {
        GRP_NONE,
        GRP_T0,
        GRP_P0,
        GRP_T1,
        GRP_P1
    } grp_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RECV,
        SQ_APPLY
    } seq_e;

    typedef struct packed {
        logic              valid;
        logic [TAB_AW-1:0] addr;
        byte_t             hi;
        byte_t             lo;
    } commit_t;

    typedef struct packed {
        logic t0;
        logic p0;
        logic t1;
        logic p1;
    } strobes_t;

    function automatic byte_t reset_value(input idx_t i);
        case (i)
            4'd0:    return 8'd4;
            4'd1:    return 8'd123;
            4'd2:    return 8'd8;
            4'd3:    return 8'd127;
            4'd4:    return 8'd4;
            4'd5:    return 8'd9;
            4'd6:    return 8'd123;
            4'd7:    return 8'd8;
            4'd8:    return 8'd127;
            4'd9:    return 8'd254;
            default: return 8'd0;
        endcase
    endfunction

    function automatic idx_t next_idx(input idx_t i);
        if (i == idx_t'(NREG - 1)) return '0;
        return i + idx_t'(1);
    endfunction

    function automatic idx_t ptr_from_byte(input byte_t b);
        if (b < byte_t'(NREG)) return b[IDX_W-1:0];
        return '0;
    endfunction

    function automatic grp_e group_of(input idx_t i);
        if (i <= 4'd2)      return GRP_T0;
        else if (i <= 4'd4) return GRP_P0;
        else if (i <= 4'd7) return GRP_T1;
        else if (i <= 4'd9) return GRP_P1;
        return GRP_NONE;
    endfunction

endpackage

// File: rtl/winreg_rxbuf.sv
module winreg_rxbuf
    import winreg_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          push,
    input  byte_t         push_byte,
    input  logic [IW-1:0] rd_idx,
    output logic [CW-1:0] count,
    output logic          overflow,
    output byte_t         rd_byte
);

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            overflow <= 1'b0;
        end else if (clear) begin
            count    <= '0;
            overflow <= 1'b0;
        end else if (push) begin
            if (count == CW'(DEPTH)) overflow <= 1'b1;
            else                     count    <= count + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clear && count < CW'(DEPTH))
            mem[count[IW-1:0]] <= push_byte;
    end

    assign rd_byte = mem[rd_idx];

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (overflow && !clear) |=> overflow);

endmodule

// File: rtl/winreg_store.sv
module winreg_store
    import winreg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  idx_t               wr_idx,
    input  byte_t              wr_byte,
    input  idx_t               rd_idx,
    output byte_t              rd_byte,
    output commit_t            commit,
    output logic [NREG*8-1:0]  cfg_flat
);

    byte_t regs [NREG];
    byte_t tab  [TAB_BYTES];

    logic [TAB_AW-1:0] taddr;
    assign taddr = regs[IDX_TADDR][TAB_AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= reset_value(idx_t'(i));
            for (int j = 0; j < TAB_BYTES; j++) tab[j] <= '0;
            commit <= '0;
        end else begin
            commit.valid <= 1'b0;
            if (wr_en) begin
                if (wr_idx == IDX_TADDR) regs[wr_idx] <= {1'b0, wr_byte[6:0]};
                else                     regs[wr_idx] <= wr_byte;
                if (wr_idx == IDX_TLO) begin
                    tab[{taddr, 1'b0}] <= regs[IDX_THI];
                    tab[{taddr, 1'b1}] <= wr_byte;
                    commit <= '{valid: 1'b1, addr: taddr,
                                hi: regs[IDX_THI], lo: wr_byte};
                end
            end
        end
    end

    always_comb begin
        if (rd_idx == IDX_THI)      rd_byte = tab[{taddr, 1'b0}];
        else if (rd_idx == IDX_TLO) rd_byte = tab[{taddr, 1'b1}];
        else                        rd_byte = regs[rd_idx];
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign cfg_flat[g*8 +: 8] = regs[g];
    end

    assert_taddr_msb_R5: assert property (@(posedge clk) disable iff (rst)
        !regs[IDX_TADDR][7]);

    assert_commit_single_R6: assert property (@(posedge clk) disable iff (rst)
        commit.valid |=> !commit.valid);

    assert_commit_follows_write_R6: assert property (@(posedge clk) disable iff (rst)
        commit.valid |-> $past(wr_en && wr_idx == IDX_TLO));

endmodule

// File: rtl/winreg_bank.sv
module winreg_bank
    import winreg_pkg::*;
#(
    parameter int RX_DEPTH = 8,
    localparam int CW = $clog2(RX_DEPTH + 1),
    localparam int IW = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               txn_start,
    input  logic               txn_stop,
    input  logic               rx_valid,
    input  logic [7:0]         rx_byte,
    input  logic               rd_req,
    output logic [7:0]         rd_data,
    output logic               tmr0_reinit,
    output logic               pwm0_update,
    output logic               tmr1_reinit,
    output logic               pwm1_update,
    output logic               commit_valid,
    output logic [6:0]         commit_addr,
    output logic [7:0]         commit_hi,
    output logic [7:0]         commit_lo,
    output logic [103:0]       cfg_flat
);

    seq_e          state;
    idx_t          ptr;
    logic [CW-1:0] apply_idx;
    logic [CW-1:0] apply_last;
    strobes_t      strb;

    logic [CW-1:0] rx_count;
    logic          rx_over;
    byte_t         buf_byte;
    byte_t         bank_rd;
    commit_t       commit;

    logic  buf_clear, buf_push, wr_en, rd_take;
    byte_t wr_byte;

    assign buf_clear = txn_start && state != SQ_APPLY;
    assign buf_push  = rx_valid && state == SQ_RECV;
    assign wr_en     = state == SQ_APPLY && apply_idx != '0;
    assign wr_byte   = buf_byte;
    assign rd_take   = rd_req && state != SQ_APPLY;

    winreg_rxbuf #(.DEPTH(RX_DEPTH)) u_rxbuf (
        .clk       (clk),
        .rst       (rst),
        .clear     (buf_clear),
        .push      (buf_push),
        .push_byte (rx_byte),
        .rd_idx    (apply_idx[IW-1:0]),
        .count     (rx_count),
        .overflow  (rx_over),
        .rd_byte   (buf_byte)
    );

    winreg_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (ptr),
        .wr_byte  (wr_byte),
        .rd_idx   (ptr),
        .rd_byte  (bank_rd),
        .commit   (commit),
        .cfg_flat (cfg_flat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_IDLE;
            ptr        <= '0;
            apply_idx  <= '0;
            apply_last <= '0;
            rd_data    <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (txn_start) state <= SQ_RECV;
                SQ_RECV: begin
                    if (txn_stop) begin
                        if (rx_count == '0 || rx_over) begin
                            state <= SQ_IDLE;
                        end else begin
                            state      <= SQ_APPLY;
                            apply_idx  <= '0;
                            apply_last <= rx_count - CW'(1);
                        end
                    end
                end
                SQ_APPLY: begin
                    if (apply_idx == '0) ptr <= ptr_from_byte(buf_byte);
                    else                 ptr <= next_idx(ptr);
                    apply_idx <= apply_idx + CW'(1);
                    if (apply_idx == apply_last) state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
            if (rd_take) begin
                rd_data <= bank_rd;
                ptr     <= next_idx(ptr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strb <= '0;
        end else begin
            strb <= '0;
            if (wr_en) begin
                case (group_of(ptr))
                    GRP_T0:  strb.t0 <= 1'b1;
                    GRP_P0:  strb.p0 <= 1'b1;
                    GRP_T1:  strb.t1 <= 1'b1;
                    GRP_P1:  strb.p1 <= 1'b1;
                    default: strb    <= '0;
                endcase
            end
        end
    end

    assign tmr0_reinit  = strb.t0;
    assign pwm0_update  = strb.p0;
    assign tmr1_reinit  = strb.t1;
    assign pwm1_update  = strb.p1;
    assign commit_valid = commit.valid;
    assign commit_addr  = commit.addr;
    assign commit_hi    = commit.hi;
    assign commit_lo    = commit.lo;

    assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tmr0_reinit, pwm0_update, tmr1_reinit, pwm1_update}));

    assert_ptr_range_R3: assert property (@(posedge clk) disable iff (rst)
        ptr < idx_t'(NREG));

    assert_read_advance_R4: assert property (@(posedge clk) disable iff (rst)
        rd_take |=> ptr == (($past(ptr) == idx_t'(NREG - 1)) ? '0 : $past(ptr) + idx_t'(1)));

    assert_strobe_after_apply_R9: assert property (@(posedge clk) disable iff (rst)
        (tmr0_reinit || pwm0_update || tmr1_reinit || pwm1_update || commit_valid)
            |-> $past(state == SQ_APPLY));

    assert_no_apply_on_discard_R8: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_RECV && txn_stop && (rx_count == '0 || rx_over)) |=> state == SQ_IDLE);

endmodule

// File: tb/winreg_bank_test.sv
module winreg_bank_test;

    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic txn_start = 1'b0, txn_stop = 1'b0, rx_valid = 1'b0, rd_req = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [7:0] rd_data, commit_hi, commit_lo;
    logic [6:0] commit_addr;
    logic tmr0_reinit, pwm0_update, tmr1_reinit, pwm1_update, commit_valid;
    logic [103:0] cfg_flat;

    always #5 clk = ~clk;

    winreg_bank #(.RX_DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .txn_start(txn_start), .txn_stop(txn_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rd_req(rd_req), .rd_data(rd_data),
        .tmr0_reinit(tmr0_reinit), .pwm0_update(pwm0_update),
        .tmr1_reinit(tmr1_reinit), .pwm1_update(pwm1_update),
        .commit_valid(commit_valid), .commit_addr(commit_addr),
        .commit_hi(commit_hi), .commit_lo(commit_lo), .cfg_flat(cfg_flat)
    );

    int errors = 0, checks = 0;
    logic [7:0] m_reg [13];
    logic [7:0] m_tab [256];
    int m_ptr;
    int exp_cnt [4];
    int got_cnt [4];
    int exp_commits = 0, got_commits = 0;
    logic [6:0] exp_caddr, got_caddr;
    logic [7:0] exp_chi, got_chi, exp_clo, got_clo;
    logic [7:0] tx [16];

    always @(negedge clk) begin
        if (!rst) begin
            if (tmr0_reinit) got_cnt[0]++;
            if (pwm0_update) got_cnt[1]++;
            if (tmr1_reinit) got_cnt[2]++;
            if (pwm1_update) got_cnt[3]++;
            if (commit_valid) begin
                got_commits++;
                got_caddr = commit_addr; got_chi = commit_hi; got_clo = commit_lo;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int grp(input int i);
        if (i <= 2) return 0;
        if (i <= 4) return 1;
        if (i <= 7) return 2;
        if (i <= 9) return 3;
        return -1;
    endfunction

    function automatic logic [7:0] m_read(input int i);
        int a = int'(m_reg[10]);
        if (i == 11) return m_tab[2*a];
        if (i == 12) return m_tab[2*a+1];
        return m_reg[i];
    endfunction

    task automatic model_init();
        logic [7:0] rv [13] = '{8'd4, 8'd123, 8'd8, 8'd127, 8'd4, 8'd9, 8'd123,
                                8'd8, 8'd127, 8'd254, 8'd0, 8'd0, 8'd0};
        for (int i = 0; i < 13; i++) m_reg[i] = rv[i];
        for (int i = 0; i < 256; i++) m_tab[i] = '0;
        for (int g = 0; g < 4; g++) begin exp_cnt[g] = 0; got_cnt[g] = 0; end
        m_ptr = 0;
    endtask

    task automatic model_apply(input int n);
        if (n < 1 || n > DEPTH) return;
        m_ptr = (tx[0] < 13) ? int'(tx[0]) : 0;
        for (int k = 1; k < n; k++) begin
            if (grp(m_ptr) >= 0) exp_cnt[grp(m_ptr)]++;
            if (m_ptr == 12) begin
                int a = int'(m_reg[10]);
                m_tab[2*a] = m_reg[11];
                m_tab[2*a+1] = tx[k];
                exp_commits++;
                exp_caddr = a[6:0]; exp_chi = m_reg[11]; exp_clo = tx[k];
            end
            m_reg[m_ptr] = (m_ptr == 10) ? {1'b0, tx[k][6:0]} : tx[k];
            m_ptr = (m_ptr == 12) ? 0 : m_ptr + 1;
        end
    endtask

    task automatic check_cfg(input string req);
        for (int i = 0; i < 13; i++)
            check(req, $sformatf("cfg reg %0d", i), int'(cfg_flat[i*8 +: 8]), int'(m_reg[i]));
    endtask

    task automatic send(input int n);
        @(negedge clk) txn_start = 1'b1;
        @(negedge clk) txn_start = 1'b0;
        for (int k = 0; k < n; k++) begin
            rx_valid = 1'b1; rx_byte = tx[k];
            @(negedge clk);
        end
        rx_valid = 1'b0;
        check("R9", "cfg before stop", int'(cfg_flat == {m_reg[12], m_reg[11], m_reg[10],
              m_reg[9], m_reg[8], m_reg[7], m_reg[6], m_reg[5], m_reg[4], m_reg[3],
              m_reg[2], m_reg[1], m_reg[0]}), 1);
        check("R9", "commits before stop", got_commits, exp_commits);
        txn_stop = 1'b1;
        @(negedge clk) txn_stop = 1'b0;
        repeat (n + 2) @(negedge clk);
        model_apply(n);
    endtask

    task automatic check_strobes(input string req);
        for (int g = 0; g < 4; g++)
            check(req, $sformatf("strobe count group %0d", g), got_cnt[g], exp_cnt[g]);
        check("R6", "commit count", got_commits, exp_commits);
    endtask

    task automatic do_read(input string req);
        logic [7:0] e;
        e = m_read(m_ptr);
        @(negedge clk) rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        check(req, $sformatf("read at %0d", m_ptr), int'(rd_data), int'(e));
        m_ptr = (m_ptr == 12) ? 0 : m_ptr + 1;
    endtask

    task automatic sweep(input string req);
        tx[0] = 8'd0;
        send(1);
        for (int i = 0; i < 14; i++) do_read(req);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_0042);
        model_init();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check_cfg("R1");
        check("R1", "rd_data", int'(rd_data), 0);
        check("R1", "strobes", int'({tmr0_reinit, pwm0_update, tmr1_reinit, pwm1_update, commit_valid}), 0);
        do_read("R1");

        // R2: pointer-only transaction and out-of-range pointer
        tx[0] = 8'd3; send(1);
        check_cfg("R2");
        do_read("R2");
        tx[0] = 8'd14; send(1);
        check("R2", "ptr model", m_ptr, 0);
        do_read("R2");

        // R6/R5: table commit through window
        tx[0] = 8'd10; tx[1] = 8'd5; tx[2] = 8'hAB; tx[3] = 8'hCD; send(4);
        check("R6", "commit addr", int'(got_caddr), 5);
        check("R6", "commit hi", int'(got_chi), 8'hAB);
        check("R6", "commit lo", int'(got_clo), 8'hCD);
        check_strobes("R7");
        tx[0] = 8'd11; send(1);
        do_read("R5"); do_read("R5");
        tx[0] = 8'd10; tx[1] = 8'd6; send(2);
        tx[0] = 8'd11; send(1);
        do_read("R5"); do_read("R5");

        // R5: address register keeps 7 bits
        tx[0] = 8'd10; tx[1] = 8'd200; send(2);
        check("R5", "reg10 masked", int'(cfg_flat[80 +: 8]), 72);

        // R3/R7: wrap from 12 to 0 while writing
        tx[0] = 8'd12; tx[1] = 8'd1; tx[2] = 8'd2; tx[3] = 8'd3; send(4);
        check("R3", "reg0 after wrap", int'(cfg_flat[7:0]), 2);
        check("R3", "reg1 after wrap", int'(cfg_flat[15:8]), 3);
        check_strobes("R7");

        // R8: length boundaries
        for (int k = 0; k < DEPTH + 1; k++) tx[k] = 8'(k + 40);
        tx[0] = 8'd2;
        send(DEPTH + 1);
        check_cfg("R8"); check_strobes("R8");
        send(0);
        check_cfg("R8"); check_strobes("R8");
        send(DEPTH);
        check_cfg("R8"); check_strobes("R8");
        sweep("R4");

        // random transactions
        for (int r = 0; r < 60; r++) begin
            int n;
            n = 1 + int'($urandom % 7);
            tx[0] = 8'($urandom % 16);
            for (int k = 1; k < n; k++) tx[k] = 8'($urandom);
            send(n);
            if (r % 10 == 9) begin
                check_cfg("R3");
                check_strobes("R7");
                sweep("R5");
            end
        end
        check("R6", "last commit addr", int'(got_caddr), int'(exp_caddr));
        check("R6", "last commit hi", int'(got_chi), int'(exp_chi));
        check("R6", "last commit lo", int'(got_clo), int'(exp_clo));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule